// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter that software uses either as a periodic interval timer or as a watchdog. One status/control byte holds the overflow flag, the mode select, a run enable and a three-bit selector. The selector picks one of eight clock-enable strobes, which come from a prescaler outside the block. Each time the counter wraps from its top value back to zero, the flag is set. In interval mode the flag drives an interrupt request. In watchdog mode the wrap also fires a fixed-length pulse on the overflow output.

Software reads the byte directly. It can change the byte only with a 16-bit write whose upper byte carries a fixed key. Clearing the flag takes a handshake: software must first read the byte while the flag shows set, then write 0 to the flag bit. If a read lands in the same cycle as the wrap, it returns the flag as 1 but does not count as the first half of the handshake. An internal reset, raised elsewhere in response to a watchdog overflow, can clear the flag directly through a dedicated input.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset, the status byte reads 0x18, the counter is zero, and both `irq_o` and `wdt_ovf_o` are low.
- R2: While the enable bit (bit 5) is 1, the counter advances by one on each cycle in which the selected strobe is high. While the enable bit is 0, the counter is held at zero.
- R3: Bits 2:0 give the index of the `tick_i` bit used as the count strobe. Strobes on the other bits have no effect on the count.
- R4: In the cycle in which the counter goes from 0xFF to 0x00, the read data already shows bit 7 as 1, and the stored flag is 1 from the next cycle on.
- R5: The flag clears only on an accepted write with bit 7 = 0 that follows an earlier read which saw the stored flag at 1. A zero-write with no such read leaves the flag set.
- R6: A read in the cycle of the wrap returns bit 7 = 1 but does not arm the clear. A later read that sees the flag set is then required.
- R7: A write is accepted only when `bus_wdata_i[15:8]` equals 0xA5. Any other write changes nothing.
- R8: Bits 4:3 always read as 1. Writing 1 to bit 7 never sets or clears the flag.
- R9: With bit 6 = 0 (interval mode), `irq_o` is high exactly while the flag is set.
- R10: With bit 6 = 1 (watchdog mode), `wdt_ovf_o` is high for PULSE_LEN cycles, starting the cycle after the wrap, and `irq_o` stays low.
- R11: A high `ovf_rst_i` clears the flag and cancels any armed clear.
- R12: If a wrap and a clear fall in the same cycle, the wrap wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 8 | Prescaled clock-enable strobes, one per selector value |
| bus_rd_i | input | 1 | Read strobe for the status byte |
| bus_wr_i | input | 1 | Write strobe; upper data byte must carry the key |
| bus_wdata_i | input | 16 | Write data: key in 15:8, new byte in 7:0 |
| ovf_rst_i | input | 1 | Internal reset request that clears the flag |
| bus_rdata_o | output | 8 | Status byte (flag, mode, enable, ones, selector) |
| irq_o | output | 1 | Interval interrupt request, level |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
The two functions that can land in the same cycle are the counter wrap, which sets the flag, and the bus accesses aimed at the flag: either the arming read or the clearing write. The bench drives the counter to 0xFF under a reference model, then issues a read (for R6) or an armed zero-write (for R12) in exactly the cycle of the wrap. It then judges the outcome by reading the byte back and attempting the clear again. Random traffic, with occasional key writes and random strobes, produces further collisions, and every output is compared with the model in every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W   = 3;
  localparam int NTAP    = 1 << SEL_W;
  localparam int BYTE_W  = 8;
  localparam int FLAG_B  = 7;
  localparam int MODE_B  = 6;
  localparam int RUN_B   = 5;
  localparam logic [BYTE_W-1:0] CSR_RESET = 8'h18;

  typedef enum logic {
    MODE_INTERVAL = 1'b0,
    MODE_WATCHDOG = 1'b1
  } wdt_mode_e;

  typedef struct packed {
    wdt_mode_e        mode;
    logic             run;
    logic [SEL_W-1:0] sel;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [NTAP-1:0]  tick_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step   = tick_i[sel_i];
  assign wrap_o = run_i & step & (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: an enabled counter without its strobe keeps its value
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !step) |=> $stable(cnt_q));
  // R4: a wrap leaves the counter at zero
  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_KEY = 8'hA5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  input  logic                wrap_i,
  input  logic                ovf_rst_i,
  output logic [BYTE_W-1:0]   rdata_o,
  output logic                flag_o,
  output wdt_ctrl_t           ctrl_o
);
  logic      flag_q, flag_d;
  logic      arm_q, arm_d;
  wdt_ctrl_t ctrl_q, ctrl_d;
  logic      key_ok, clr_req;

  assign key_ok  = wr_i && (wdata_i[2*BYTE_W-1:BYTE_W] == WR_KEY);
  assign clr_req = key_ok && !wdata_i[FLAG_B] && arm_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (key_ok) begin
      ctrl_d.mode = wdt_mode_e'(wdata_i[MODE_B]);
      ctrl_d.run  = wdata_i[RUN_B];
      ctrl_d.sel  = wdata_i[SEL_W-1:0];
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (wrap_i)                    flag_d = 1'b1;
    else if (ovf_rst_i || clr_req) flag_d = 1'b0;
  end

  always_comb begin
    arm_d = arm_q;
    if (ovf_rst_i)                arm_d = 1'b0;
    else if (clr_req && !wrap_i)  arm_d = 1'b0;
    else if (rd_i && flag_q)      arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= CSR_RESET[FLAG_B];
      arm_q  <= 1'b0;
      ctrl_q <= '{mode: wdt_mode_e'(CSR_RESET[MODE_B]), run: CSR_RESET[RUN_B],
                  sel: CSR_RESET[SEL_W-1:0]};
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign rdata_o = {flag_q | wrap_i, ctrl_q.mode, ctrl_q.run, 2'b11, ctrl_q.sel};
  assign flag_o  = flag_q;
  assign ctrl_o  = ctrl_q;

  // R4: a wrap is always recorded in the flag
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_q);
  // R5: the flag falls only after an armed clear or an internal reset
  p_clear_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q || ovf_rst_i));
  // R6: a read colliding with the wrap does not arm the clear
  p_collide_noarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && wrap_i && !flag_q && !arm_q) |=> !arm_q);
  // R7: writes without the key leave the control fields untouched
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[2*BYTE_W-1:BYTE_W] != WR_KEY) |=> $stable(ctrl_q));
  // R8: the fixed bits always read as ones
  p_fixed_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_o[4:3] == 2'b11);
  // R11: internal reset leaves the flag clear unless a wrap coincides
  p_int_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_rst_i && !wrap_i) |=> (!flag_q && !arm_q));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_LEN);

  logic [PC_W-1:0] left_q, left_d;

  always_comb begin
    left_d = left_q;
    if (trig_i)            left_d = PC_LOAD;
    else if (left_q != '0) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse_o = (left_q != '0);

  // R10: a trigger opens the pulse in the next cycle
  p_pulse_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o);
endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
  import wdt_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter int          PULSE_LEN = 4,
  parameter logic [7:0]  WR_KEY    = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  tick_i,
  input  logic        bus_rd_i,
  input  logic        bus_wr_i,
  input  logic [15:0] bus_wdata_i,
  input  logic        ovf_rst_i,
  output logic [7:0]  bus_rdata_o,
  output logic        irq_o,
  output logic        wdt_ovf_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       wrap, flag;
  wdt_ctrl_t  ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .run_i  (ctrl.run),
    .sel_i  (ctrl.sel),
    .tick_i (tick_i),
    .wrap_o (wrap)
  );

  wdt_csr #(.WR_KEY(WR_KEY)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .wdata_i   (bus_wdata_i),
    .wrap_i    (wrap),
    .ovf_rst_i (ovf_rst_i),
    .rdata_o   (bus_rdata_o),
    .flag_o    (flag),
    .ctrl_o    (ctrl)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .trig_i  (wrap && ctrl.mode == MODE_WATCHDOG),
    .pulse_o (wdt_ovf_o)
  );

  assign irq_o = flag && (ctrl.mode == MODE_INTERVAL);

  // R9: the interrupt request never appears in watchdog mode
  p_irq_mode_r9: assert property (@(posedge clk) disable iff (!rst_n_int)
    irq_o |-> (ctrl.mode == MODE_INTERVAL && flag));
  // R10: the overflow pulse only begins after a watchdog-mode wrap
  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(wdt_ovf_o) |-> $past(wrap && ctrl.mode == MODE_WATCHDOG));
endmodule

// File: tb/wdog_interval_timer_bench.sv
module wdog_interval_timer_bench;
  localparam int PULSE_LEN = 4;

  logic        clk;
  logic        rst_n;
  logic [7:0]  tick_i;
  logic        bus_rd_i, bus_wr_i, ovf_rst_i;
  logic [15:0] bus_wdata_i;
  logic [7:0]  bus_rdata_o;
  logic        irq_o, wdt_ovf_o;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  // reference model state
  logic [7:0] m_cnt;
  logic       m_flag, m_arm, m_mode, m_run;
  logic [2:0] m_sel;
  int         m_left;

  wdog_interval_timer #(.PULSE_LEN(PULSE_LEN)) u_wdog_interval_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_rd_i(bus_rd_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .ovf_rst_i(ovf_rst_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic wrap_now(input logic [7:0] tk);
    return m_run && tk[m_sel] && (m_cnt == 8'hFF);
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [7:0] tk);
    return {m_flag | wrap_now(tk), m_mode, m_run, 2'b11, m_sel};
  endfunction

  task automatic cycle(input logic rd, input logic wr, input logic [15:0] wd,
                       input logic [7:0] tk, input logic orst);
    logic w, key, clr;
    @(negedge clk);
    bus_rd_i = rd; bus_wr_i = wr; bus_wdata_i = wd; tick_i = tk; ovf_rst_i = orst;
    #1;
    chk({tag, " irq"}, {7'b0, irq_o}, {7'b0, m_flag && !m_mode});
    chk({tag, " wdt_ovf"}, {7'b0, wdt_ovf_o}, {7'b0, m_left != 0});
    if (rd) chk({tag, " rdata"}, bus_rdata_o, exp_rdata(tk));
    w   = wrap_now(tk);
    key = wr && (wd[15:8] == 8'hA5);
    clr = key && !wd[7] && m_arm;
    @(posedge clk);
    if (orst)            m_arm = 1'b0;
    else if (clr && !w)  m_arm = 1'b0;
    else if (rd && m_flag) m_arm = 1'b1;
    if (w)               m_flag = 1'b1;
    else if (orst || clr) m_flag = 1'b0;
    if (w && m_mode)     m_left = PULSE_LEN;
    else if (m_left != 0) m_left--;
    if (!m_run)          m_cnt = 8'h00;
    else if (tk[m_sel])  m_cnt = m_cnt + 8'h01;
    if (key) begin
      m_mode = wd[6]; m_run = wd[5]; m_sel = wd[2:0];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 16'h0, 8'h00, 1'b0);
  endtask

  task automatic run_to_ff(input logic [7:0] tk);
    for (int i = 0; i < 600 && m_cnt != 8'hFF; i++) cycle(1'b0, 1'b0, 16'h0, tk, 1'b0);
  endtask

  task automatic flag_now(input string req, input logic exp);
    cycle(1'b1, 1'b0, 16'h0, 8'h00, 1'b0);
    chk({req, " flag"}, {7'b0, bus_rdata_o[7]}, {7'b0, exp});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst_n = 1'b0; tick_i = 8'h00; bus_rd_i = 1'b0; bus_wr_i = 1'b0;
    bus_wdata_i = 16'h0; ovf_rst_i = 1'b0;
    m_cnt = 8'h00; m_flag = 1'b0; m_arm = 1'b0; m_mode = 1'b0; m_run = 1'b0;
    m_sel = 3'd0; m_left = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset value and quiet outputs
    tag = "R1";
    cycle(1'b1, 1'b0, 16'h0, 8'hFF, 1'b0);
    chk("R1 reset byte", bus_rdata_o, 8'h18);

    // R7: wrong key is ignored
    tag = "R7";
    cycle(1'b0, 1'b1, 16'h5A27, 8'h00, 1'b0);
    cycle(1'b1, 1'b0, 16'h0, 8'h00, 1'b0);
    chk("R7 locked", bus_rdata_o, 8'h18);

    // R2 and R3: enable, tap 3; other taps must not count
    tag = "R3";
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    for (int i = 0; i < 300; i++) cycle(1'b0, 1'b0, 16'h0, 8'hF7, 1'b0);
    flag_now("R3 other taps", 1'b0);
    tag = "R2";
    for (int i = 0; i < 255; i++) begin
      cycle(1'b0, 1'b0, 16'h0, 8'h08, 1'b0);
      cycle(1'b0, 1'b0, 16'h0, 8'h00, 1'b0);
    end
    flag_now("R2 255 steps", 1'b0);
    tag = "R4";
    cycle(1'b1, 1'b0, 16'h0, 8'h08, 1'b0);
    chk("R4 wrap read", bus_rdata_o, 8'hBB);
    idle(1);
    chk("R9 irq level", {7'b0, irq_o}, 8'h01);

    // R5: zero-write without a prior read keeps the flag
    tag = "R5";
    idle(1);
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    flag_now("R5 unarmed write", 1'b1);
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    flag_now("R5 armed write", 1'b0);

    // R6: read in the wrap cycle does not arm
    tag = "R6";
    run_to_ff(8'h08);
    cycle(1'b1, 1'b0, 16'h0, 8'h08, 1'b0);
    chk("R6 collide read", {7'b0, bus_rdata_o[7]}, 8'h01);
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    flag_now("R6 still set", 1'b1);
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    flag_now("R6 second read clears", 1'b0);

    // R12: armed clear collides with a wrap
    tag = "R12";
    run_to_ff(8'h08);
    cycle(1'b0, 1'b0, 16'h0, 8'h08, 1'b0);
    cycle(1'b1, 1'b0, 16'h0, 8'h00, 1'b0);
    run_to_ff(8'h08);
    cycle(1'b0, 1'b1, 16'hA523, 8'h08, 1'b0);
    flag_now("R12 wrap wins", 1'b1);

    // R11: internal reset clears flag and arming
    tag = "R11";
    cycle(1'b1, 1'b0, 16'h0, 8'h00, 1'b0);
    cycle(1'b0, 1'b0, 16'h0, 8'h00, 1'b1);
    flag_now("R11 cleared", 1'b0);
    run_to_ff(8'h08);
    cycle(1'b0, 1'b0, 16'h0, 8'h08, 1'b0);
    cycle(1'b0, 1'b1, 16'hA523, 8'h00, 1'b0);
    flag_now("R11 arm cancelled", 1'b1);
    cycle(1'b0, 1'b0, 16'h0, 8'h00, 1'b1);

    // R8: bit 7 write of one, fixed ones; switches to watchdog, tap 7
    tag = "R8";
    cycle(1'b0, 1'b1, 16'hA5FF, 8'h00, 1'b0);
    cycle(1'b1, 1'b0, 16'h0, 8'h00, 1'b0);
    chk("R8 byte", bus_rdata_o, 8'h7F);

    // R10: watchdog pulse width
    tag = "R10";
    run_to_ff(8'h80);
    cycle(1'b0, 1'b0, 16'h0, 8'h80, 1'b0);
    for (int i = 0; i < PULSE_LEN; i++) begin
      idle(1);
      chk("R10 pulse high", {7'b0, wdt_ovf_o}, 8'h01);
      chk("R10 irq low", {7'b0, irq_o}, 8'h00);
    end
    idle(1);
    chk("R10 pulse end", {7'b0, wdt_ovf_o}, 8'h00);

    // random traffic against the model
    tag = "R2";
    for (int i = 0; i < 6000; i++) begin
      logic rd, wr, orst;
      logic [15:0] wd;
      logic [7:0] tk;
      rd   = ($urandom % 4) == 0;
      wr   = ($urandom % 40) == 0;
      orst = ($urandom % 500) == 0;
      wd   = {(($urandom % 2) == 0) ? 8'hA5 : 8'($urandom), 8'($urandom) | 8'h20};
      tk   = 8'($urandom);
      cycle(rd, wr, wd, tk, orst);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule